// File: doc/BRIEF.md
# Nibble-Parallel Transmit Payload Ingress

This block is the entry stage of a framer's transmit path when the upstream equipment delivers payload four bits at a time and the framer supplies the timing. A single high-rate line clock drives it. From that clock the block derives a quarter-rate nibble clock and sends it to the upstream equipment. The upstream side launches one nibble per nibble-clock period. The block captures each nibble at a fixed line-clock edge and replays its bits serially, one per line-clock cycle, so that the stream that leaves it is aligned to the line clock.

An external frame-reference input marks where an outbound frame begins. The block stays idle until it first sees a rising edge on that input. On every such edge it restarts its nibble phase, so that the first nibble of the frame lines up with the frame start. A mode selection input and a loopback request are also handled here. Loopback is only granted in interface modes that can support it. A request made in any other mode is refused and leaves a sticky error flag set.

Neither side of the stream can apply back-pressure. Upstream there is no ready signal: the nibble clock paces the source, and the source must present a new nibble every nibble-clock period. Downstream, `ser_valid` qualifies `ser_out`. The consumer must take one bit on every line-clock cycle in which `ser_valid` is high, because the block has no storage in which to hold a bit back.

Top module: `nibtx_ingress`

## Requirements
- R1: After reset, and until the first frame-reference rising edge, `nib_clk`, `ser_out`, `ser_valid`, `frame_mark`, `lpbk_en` and `mode_err` are all 0, whatever is driven on `nib_in`.
- R2: A frame-reference rising edge is detected at a `clk_line` edge where `frame_ref` is 1 and was 0 at the previous edge. Holding `frame_ref` high causes no further resynchronisation.
- R3: `nib_clk` is a registered output with a period of four `clk_line` cycles: high for two and low for two. It goes high on the edge that detects a frame-reference rising edge.
- R4: `nib_in` is captured on the third `clk_line` rising edge after the edge on which `nib_clk` goes high.
- R5: On the capture edge, `ser_out` takes bit 3 of the captured nibble. Bits 2, 1 and 0 follow on the next three edges, and `ser_valid` is 1 while these bits are presented. In steady state the output stream has no gaps.
- R6: On a detected frame-reference rising edge, the shift register is flushed and `ser_out` and `ser_valid` go to 0 until the next capture. A capture that would fall on that same edge is dropped.
- R7: `frame_mark` is 1 for exactly the one cycle that carries the first serial bit after each resynchronisation.
- R8: `lpbk_en` is registered and equals `lpbk_req` when `mode_sel` (3-bit binary mode number) is 2, 3, 5 or 6.
- R9: When `lpbk_req` is 1 while `mode_sel` is 0, 1, 4 or 7, `lpbk_en` is 0 and `mode_err` becomes 1. `mode_err` stays 1 until reset.
- R10: `ser_out` is 0 whenever `ser_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line | input | 1 | Line clock, the transmit timing reference |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ref | input | 1 | Frame reference; a rising edge starts an outbound frame |
| nib_in | input | 4 | Payload nibble from the upstream equipment |
| mode_sel | input | 3 | Interface mode number |
| lpbk_req | input | 1 | Local loopback request |
| nib_clk | output | 1 | Quarter-rate nibble clock sent to the upstream equipment |
| ser_out | output | 1 | Serial payload bit, MSB of each nibble first |
| ser_valid | output | 1 | Qualifies `ser_out` |
| frame_mark | output | 1 | Marks the first serial bit after a frame start |
| lpbk_en | output | 1 | Granted loopback enable |
| mode_err | output | 1 | Sticky flag for a refused loopback request |

## Verification
The bench checks the exact capture edge by giving each nibble a distinct bit pattern and comparing every serial bit in every cycle. A design that captured one edge early or late would emit bits from the wrong nibble, and one that shifted LSB first would emit the pattern reversed. It holds the frame reference high for many cycles to catch a level-sensitive resync, which would freeze the nibble clock. It then raises the reference again on exactly the edge where a capture is due, so that a design giving the capture priority over the flush would leave `ser_valid` high. The loopback table walks the allowed and refused modes, including a return to an allowed mode after an error, and a second reset. This catches a design that drops the flag early or that grants loopback in mode 4.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;

  localparam int MODE_W = 3;

  typedef logic [MODE_W-1:0] ifmode_t;

  localparam ifmode_t IFM_SER_SLAVE  = 3'd2;
  localparam ifmode_t IFM_SER_MASTER = 3'd3;
  localparam ifmode_t IFM_NIB_SLAVE  = 3'd5;
  localparam ifmode_t IFM_NIB_MASTER = 3'd6;

  // True for the modes in which the local loopback path can be used
  function automatic logic loop_allowed(input ifmode_t m);
    return (m == IFM_SER_SLAVE) || (m == IFM_SER_MASTER) ||
           (m == IFM_NIB_SLAVE) || (m == IFM_NIB_MASTER);
  endfunction

endpackage

// File: rtl/nibtx_phase_gen.sv
module nibtx_phase_gen #(
  parameter int DIV_RATIO = 4,
  parameter int CAP_EDGE  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resync,
  output logic running,
  output logic nib_clk,
  output logic cap_stb
);
  localparam int PH_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam int HALF = DIV_RATIO / 2;
  localparam logic [PH_W-1:0] CAP_PH  = PH_W'(CAP_EDGE - 1);
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(HALF);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_next;

  assign ph_next = ph + PH_W'(1);

  // The capture edge is counted from the nibble-clock rising edge; a resync wins
  assign cap_stb = running && !resync && (ph == CAP_PH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      ph      <= '0;
      nib_clk <= 1'b0;
    end else if (resync) begin
      running <= 1'b1;
      ph      <= '0;
      nib_clk <= 1'b1;
    end else if (running) begin
      ph      <= ph_next;
      nib_clk <= (ph_next < HALF_PH);
    end
  end

endmodule

// File: rtl/nibtx_shifter.sv
module nibtx_shifter #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [NIB_W-1:0] nib,
  output logic             ser_out,
  output logic             ser_valid,
  output logic             first_bit
);
  localparam int CNT_W = $clog2(NIB_W) + 1;

  logic [NIB_W-1:0] sh;
  logic [CNT_W-1:0] remain;
  logic             mark_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      remain    <= '0;
      ser_out   <= 1'b0;
      ser_valid <= 1'b0;
      first_bit <= 1'b0;
      mark_pend <= 1'b0;
    end else if (flush) begin
      sh        <= '0;
      remain    <= '0;
      ser_out   <= 1'b0;
      ser_valid <= 1'b0;
      first_bit <= 1'b0;
      mark_pend <= 1'b1;
    end else if (load) begin
      ser_out   <= nib[NIB_W-1];
      sh        <= {nib[NIB_W-2:0], 1'b0};
      remain    <= CNT_W'(NIB_W - 1);
      ser_valid <= 1'b1;
      first_bit <= mark_pend;
      mark_pend <= 1'b0;
    end else if (remain != '0) begin
      ser_out   <= sh[NIB_W-1];
      sh        <= {sh[NIB_W-2:0], 1'b0};
      remain    <= remain - CNT_W'(1);
      first_bit <= 1'b0;
    end else begin
      ser_out   <= 1'b0;
      ser_valid <= 1'b0;
      first_bit <= 1'b0;
    end
  end

endmodule

// File: rtl/nibtx_lpbk_guard.sv
module nibtx_lpbk_guard
  import nibtx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ifmode_t mode_sel,
  input  logic    lpbk_req,
  output logic    lpbk_en,
  output logic    mode_err
);
  logic ok;

  assign ok = loop_allowed(mode_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lpbk_en  <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      lpbk_en <= lpbk_req && ok;
      if (lpbk_req && !ok) mode_err <= 1'b1;
    end
  end

endmodule

// File: rtl/nibtx_ingress.sv
module nibtx_ingress
  import nibtx_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int CAP_EDGE = 3
) (
  input  logic             clk_line,
  input  logic             rst_n,
  input  logic             frame_ref,
  input  logic [NIB_W-1:0] nib_in,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic             lpbk_req,
  output logic             nib_clk,
  output logic             ser_out,
  output logic             ser_valid,
  output logic             frame_mark,
  output logic             lpbk_en,
  output logic             mode_err
);
  // One nibble per divided-clock period: the divider ratio equals the nibble width
  localparam int DIV_RATIO = NIB_W;

  logic fr_q;
  logic fr_rise;
  logic running;
  logic cap_stb;

  always_ff @(posedge clk_line) begin
    if (!rst_n) fr_q <= 1'b0;
    else        fr_q <= frame_ref;
  end

  assign fr_rise = frame_ref && !fr_q;

  nibtx_phase_gen #(
    .DIV_RATIO(DIV_RATIO),
    .CAP_EDGE (CAP_EDGE)
  ) u_phase (
    .clk    (clk_line),
    .rst_n  (rst_n),
    .resync (fr_rise),
    .running(running),
    .nib_clk(nib_clk),
    .cap_stb(cap_stb)
  );

  nibtx_shifter #(
    .NIB_W(NIB_W)
  ) u_shift (
    .clk      (clk_line),
    .rst_n    (rst_n),
    .flush    (fr_rise),
    .load     (cap_stb),
    .nib      (nib_in),
    .ser_out  (ser_out),
    .ser_valid(ser_valid),
    .first_bit(frame_mark)
  );

  nibtx_lpbk_guard u_lpbk (
    .clk     (clk_line),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .lpbk_req(lpbk_req),
    .lpbk_en (lpbk_en),
    .mode_err(mode_err)
  );

endmodule

// File: rtl/nibtx_ingress_chk.sv
module nibtx_ingress_chk
  import nibtx_pkg::*;
(
  input logic          clk_line,
  input logic          rst_n,
  input logic [MODE_W-1:0] mode_sel,
  input logic          nib_clk,
  input logic          ser_out,
  input logic          ser_valid,
  input logic          lpbk_en,
  input logic          mode_err,
  input logic          fr_rise,
  input logic          running,
  input logic          cap_stb
);

  assert_nibclk_high_two_R3: assert property (@(posedge clk_line) disable iff (!rst_n)
    $rose(nib_clk) |=> nib_clk);

  assert_nibclk_low_two_R3: assert property (@(posedge clk_line) disable iff (!rst_n)
    ($fell(nib_clk) && !fr_rise) |=> !nib_clk);

  assert_idle_until_frame_R1: assert property (@(posedge clk_line) disable iff (!rst_n)
    !running |-> (!nib_clk && !ser_valid));

  assert_capture_edge_R4: assert property (@(posedge clk_line) disable iff (!rst_n)
    cap_stb |-> (!nib_clk && $past(nib_clk) && $past(nib_clk, 2)));

  assert_resync_flush_R6: assert property (@(posedge clk_line) disable iff (!rst_n)
    fr_rise |=> (!ser_valid && nib_clk));

  assert_lpbk_mode_R8: assert property (@(posedge clk_line) disable iff (!rst_n)
    lpbk_en |-> loop_allowed($past(mode_sel)));

  assert_err_sticky_R9: assert property (@(posedge clk_line) disable iff (!rst_n)
    mode_err |=> mode_err);

  assert_quiet_when_invalid_R10: assert property (@(posedge clk_line) disable iff (!rst_n)
    !ser_valid |-> !ser_out);

endmodule

bind nibtx_ingress nibtx_ingress_chk u_chk (
  .clk_line (clk_line),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .nib_clk  (nib_clk),
  .ser_out  (ser_out),
  .ser_valid(ser_valid),
  .lpbk_en  (lpbk_en),
  .mode_err (mode_err),
  .fr_rise  (fr_rise),
  .running  (running),
  .cap_stb  (cap_stb)
);

// File: tb/tb_nibtx_ingress.sv
`timescale 1ns/1ps
module tb_nibtx_ingress;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_ref = 1'b0;
  logic [3:0] nib_in = 4'h0;
  logic [2:0] mode_sel = 3'd0;
  logic       lpbk_req = 1'b0;
  logic       nib_clk, ser_out, ser_valid, frame_mark, lpbk_en, mode_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  nibtx_ingress dut (
    .clk_line  (clk),
    .rst_n     (rst_n),
    .frame_ref (frame_ref),
    .nib_in    (nib_in),
    .mode_sel  (mode_sel),
    .lpbk_req  (lpbk_req),
    .nib_clk   (nib_clk),
    .ser_out   (ser_out),
    .ser_valid (ser_valid),
    .frame_mark(frame_mark),
    .lpbk_en   (lpbk_en),
    .mode_err  (mode_err)
  );

  // Payload nibbles, each with a distinct bit pattern
  localparam logic [3:0] VEC [8] = '{4'hA, 4'h5, 4'hF, 4'h0, 4'h9, 4'h6, 4'h3, 4'hC};

  // Loopback vectors {mode, req, expected lpbk_en, expected mode_err}
  localparam logic [5:0] LBV [11] = '{
    {3'd5, 1'b1, 1'b1, 1'b0}, {3'd2, 1'b1, 1'b1, 1'b0}, {3'd3, 1'b1, 1'b1, 1'b0},
    {3'd6, 1'b1, 1'b1, 1'b0}, {3'd6, 1'b0, 1'b0, 1'b0}, {3'd4, 1'b0, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b1, 1'b1, 1'b1}, {3'd7, 1'b1, 1'b0, 1'b1},
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd5, 1'b1, 1'b1, 1'b1}};

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {nib_clk, ser_out, ser_valid, frame_mark}, 4'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    chk_idle("R1 reset state");
    chk("R1 reset lpbk/err", {2'b00, lpbk_en, mode_err}, 4'h0);

    // R1: nibble bus activity before any frame reference leaves the block idle
    for (int i = 0; i < 6; i++) begin
      nib_in = VEC[i];
      tick();
      chk_idle("R1 idle before frame");
    end

    // R8 / R9: loopback table
    for (int i = 0; i < 11; i++) begin
      mode_sel = LBV[i][5:3];
      lpbk_req = LBV[i][2];
      tick();
      chk(LBV[i][0] ? "R9 loopback vector" : "R8 loopback vector",
          {2'b00, lpbk_en, mode_err}, {2'b00, LBV[i][1], LBV[i][0]});
      chk_idle("R1 idle during loopback");
    end
    lpbk_req = 1'b0;

    // R9: only reset clears the sticky flag
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R9 error cleared by reset", {2'b00, lpbk_en, mode_err}, 4'h0);

    // R2..R7: frame start, then stream; j counts edges after the detecting edge
    frame_ref = 1'b1;
    nib_in = VEC[0];
    tick();
    for (int j = 0; j < 35; j++) begin
      chk("R3 nib_clk", {3'b000, nib_clk}, {3'b000, ((j % 4) < 2)});
      if (j >= 3) begin
        chk("R5 ser_out", {3'b000, ser_out}, {3'b000, VEC[(j - 3) / 4][3 - ((j - 3) % 4)]});
        chk("R5 ser_valid", {3'b000, ser_valid}, 4'h1);
        chk("R7 frame_mark", {3'b000, frame_mark}, {3'b000, (j == 3)});
      end else begin
        chk("R10 quiet before capture", {2'b00, ser_valid, ser_out}, 4'h0);
        chk("R4 no early capture", {3'b000, frame_mark}, 4'h0);
      end
      if (j == 10) frame_ref = 1'b0;   // R2: level held high for 11 edges
      if (j % 4 == 0 && j / 4 < 8) nib_in = VEC[j / 4];
      if (j == 34) begin
        frame_ref = 1'b1;              // R6: next edge is a due capture edge
        nib_in = 4'hB;
      end
      tick();
    end

    // R6: resync on the capture edge drops that capture and flushes
    chk("R6 flush nib_clk", {3'b000, nib_clk}, 4'h1);
    chk("R6 flush output", {2'b00, ser_valid, ser_out}, 4'h0);
    tick();
    chk("R6 after flush +1", {nib_clk, ser_valid, ser_out, frame_mark}, 4'h8);
    tick();
    chk("R6 after flush +2", {nib_clk, ser_valid, ser_out, frame_mark}, 4'h0);
    tick();
    chk("R7 first bit after resync", {nib_clk, ser_valid, ser_out, frame_mark}, 4'h7);
    tick();
    chk("R5 bit2 after resync", {nib_clk, ser_valid, ser_out, frame_mark}, 4'hC);
    tick();
    chk("R5 bit1 after resync", {nib_clk, ser_valid, ser_out, frame_mark}, 4'hE);
    tick();
    chk("R5 bit0 after resync", {nib_clk, ser_valid, ser_out, frame_mark}, 4'h6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule